// File: doc/BRIEF.md
# Jitter Sample XOR Decimator

This block condenses a stream of raw one-bit samples into true random bits. Each raw sample is taken by a flip-flop that captures a reference clock with a second clock synthesized from it. That second clock runs at the reference frequency times KM/KD, with KM and KD coprime. A single sample carries little entropy and is heavily biased. The block folds KD consecutive accepted samples into one output bit by modulo-2 accumulation (parity), so it emits one bit per decimation period. With the default KD of 3333 and a 33.3 MHz system clock, that is roughly 10,000 bits per second.

Each accepted sample may itself be the XOR of several independent raw lanes, for example taps along a delay line. The lanes are folded together before they enter the accumulator. The input side uses a valid/ready pair, and ready is always high: the sampler cannot be stalled, so the block never back-pressures. Cycles with `raw_valid` low are simply not counted. The output side is a one-entry valid/ready register. A held bit stays stable until the consumer takes it. If a newer bit completes before the held one is taken, the newer bit replaces it, so the freshest entropy wins. With `out_ready` tied high, `out_valid` is a single-cycle strobe once per period.

Top module: `xd_decimator`

## Requirements
- R1: A synchronous active-high `rst` drives `out_valid` low in the next cycle and restarts the period. After reset, no bit appears until KD further samples have been accepted.
- R2: Each output bit equals the XOR of exactly KD consecutive accepted samples. Each accepted sample is the XOR of all bits of `raw_bits`.
- R3: `out_valid` is high in the cycle after the edge at which the KD-th sample of a period is accepted.
- R4: Cycles with `raw_valid` low neither advance the period count nor change the parity, whatever `raw_bits` carries.
- R5: `raw_ready` is high in every cycle.
- R6: While `out_valid` is high and `out_ready` is low, and no new period completes, `out_valid` stays high and `out_bit` holds its value.
- R7: When the consumer takes a bit (`out_valid` and `out_ready` high) in the same cycle that a new period completes, `out_valid` stays high in the next cycle and shows the new bit.
- R8: If a period completes while an untaken bit is held, the new bit replaces the held bit.
- R9: Periods follow one another without a gap. The sample accepted after a period's last sample is the first sample of the next period, and no sample is dropped or counted twice.
- R10: All LANES bits of `raw_bits` contribute to each sample. Flipping any single lane of one accepted sample inverts that period's output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Raw sample present this cycle |
| raw_ready | output | 1 | Always high; the block never stalls the sampler |
| raw_bits | input | LANES | Raw jitter samples, one per lane |
| out_valid | output | 1 | A random bit is held on out_bit |
| out_ready | input | 1 | Consumer takes the held bit |
| out_bit | output | 1 | Decimated random bit |

## Verification
Two events can fall in the same cycle: the consumer taking a held bit and the completion of the next period. The bench provokes this by holding `out_ready` low for a whole period and raising it only during the cycle in which the period's last sample is accepted. It then expects `out_valid` to stay high with the new parity. A neighbouring case, completion while the old bit is still untaken, is provoked by holding ready low across several periods. There the latest parity must replace the held bit. The behavioural model in the bench decides both outcomes cycle by cycle.

// File: rtl/xd_pkg.sv
package xd_pkg;
  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xd_lane_fold.sv
module xd_lane_fold #(
  parameter int unsigned LANES = 1
) (
  input  logic [LANES-1:0] lanes,
  output logic             folded
);
  logic [LANES:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < LANES; i++) begin : g_fold
    assign chain[i+1] = chain[i] ^ lanes[i];
  end
  assign folded = chain[LANES];
endmodule

// File: rtl/xd_period_counter.sv
module xd_period_counter #(
  parameter int unsigned KD = 3333,
  localparam int unsigned CW = xd_pkg::cnt_width(KD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic          first,
  output logic          last,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LAST_POS = CW'(KD - 1);

  assign first = (count == '0);
  assign last  = (count == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      count <= last ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/xd_parity_acc.sv
module xd_parity_acc (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic first,
  input  logic last,
  input  logic sample,
  output logic done,
  output logic parity
);
  logic acc;

  // First sample of a period loads the accumulator, so nothing is lost.
  assign parity = first ? sample : (acc ^ sample);
  assign done   = step & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= 1'b0;
    end else if (step) begin
      acc <= parity;
    end
  end
endmodule

// File: rtl/xd_out_stage.sv
module xd_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_bit,
  input  logic ready,
  output logic valid,
  output logic data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_bit;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xd_decimator.sv
module xd_decimator #(
  parameter int unsigned KD    = 3333,
  parameter int unsigned LANES = 1,
  localparam int unsigned CW   = xd_pkg::cnt_width(KD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_valid,
  output logic             raw_ready,
  input  logic [LANES-1:0] raw_bits,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit
);
  logic          sample;
  logic          first;
  logic          last;
  logic          period_done;
  logic          parity;
  logic [CW-1:0] cnt;

  assign raw_ready = 1'b1;

  xd_lane_fold #(.LANES(LANES)) u_fold (
    .lanes  (raw_bits),
    .folded (sample)
  );

  xd_period_counter #(.KD(KD)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (raw_valid),
    .first (first),
    .last  (last),
    .count (cnt)
  );

  xd_parity_acc u_acc (
    .clk    (clk),
    .rst    (rst),
    .step   (raw_valid),
    .first  (first),
    .last   (last),
    .sample (sample),
    .done   (period_done),
    .parity (parity)
  );

  xd_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (period_done),
    .load_bit (parity),
    .ready    (out_ready),
    .valid    (out_valid),
    .data     (out_bit)
  );
endmodule

// File: rtl/xd_decimator_chk.sv
module xd_decimator_chk #(
  parameter int unsigned KD = 3333,
  localparam int unsigned CW = xd_pkg::cnt_width(KD)
) (
  input logic          clk,
  input logic          rst,
  input logic          raw_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_bit,
  input logic          last_accept,
  input logic [CW-1:0] count
);
  // R3
  a_r3_valid_after_period: assert property (@(posedge clk) disable iff (rst)
    last_accept |=> out_valid);

  // R4
  a_r4_idle_no_count: assert property (@(posedge clk) disable iff (rst)
    !raw_valid |=> $stable(count));

  // R6
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !last_accept) |=> (out_valid && $stable(out_bit)));

  // R7
  a_r7_take_clears: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !last_accept) |=> !out_valid);

  // R9
  a_r9_count_in_range: assert property (@(posedge clk) disable iff (rst)
    raw_valid |=> (count < CW'(KD)) || (KD == (1 << CW)));
endmodule

bind xd_decimator xd_decimator_chk #(.KD(KD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .raw_valid   (raw_valid),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_bit     (out_bit),
  .last_accept (period_done),
  .count       (cnt)
);

// File: tb/tb_xd_decimator.sv
`timescale 1ns/1ps
module tb_xd_decimator;
  localparam int KD    = 7;
  localparam int LANES = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             raw_valid = 1'b0;
  logic             raw_ready;
  logic [LANES-1:0] raw_bits = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic             out_bit;

  always #10 clk = ~clk;

  xd_decimator #(.KD(KD), .LANES(LANES)) dut (
    .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_ready(raw_ready),
    .raw_bits(raw_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string tag = "R1";

  // Behavioural reference model.
  int   m_cnt = 0;
  logic m_par = 1'b0;
  logic m_v   = 1'b0;
  logic m_b   = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_par = 1'b0; m_v = 1'b0; m_b = 1'b0;
    end else begin
      if (m_v && out_ready) m_v = 1'b0;
      if (raw_valid) begin
        m_par = (m_cnt == 0) ? ^raw_bits : (m_par ^ (^raw_bits));
        m_cnt++;
        if (m_cnt == KD) begin
          m_cnt = 0; m_v = 1'b1; m_b = m_par;
        end
      end
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== m_v) begin
      errors++;
      $display("FAIL %s out_valid got %b expected %b", tag, out_valid, m_v);
    end
    if (m_v) begin
      checks++;
      if (out_bit !== m_b) begin
        errors++;
        $display("FAIL %s out_bit got %b expected %b", tag, out_bit, m_b);
      end
    end
    checks++;
    if (raw_ready !== 1'b1) begin
      errors++;
      $display("FAIL R5 raw_ready got %b expected 1", raw_ready);
    end
  endtask

  task automatic cyc(input logic v, input logic [LANES-1:0] b, input logic rdy);
    @(negedge clk);
    compare();
    raw_valid = v; raw_bits = b; out_ready = rdy;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) cyc(1'b1, 3'b111, 1'b1);
    @(negedge clk); compare(); rst = 1'b0;
    // R3: first bit only after a full KD samples
    tag = "R3";
    for (int i = 0; i < 3 * KD; i++) cyc(1'b1, 3'(i % 2), 1'b1);
    // R2: fixed patterns
    tag = "R2";
    for (int i = 0; i < 2 * KD; i++) cyc(1'b1, 3'b000, 1'b1);
    for (int i = 0; i < 2 * KD; i++) cyc(1'b1, 3'b001, 1'b1);
    for (int i = 0; i < 3 * KD; i++) cyc(1'b1, 3'(i % 3), 1'b1);
    // R9: long back-to-back run
    tag = "R9";
    for (int i = 0; i < 20 * KD; i++) cyc(1'b1, 3'($urandom), 1'b1);
    // R10: single-lane flips over a fixed background
    tag = "R10";
    for (int l = 0; l < LANES; l++) begin
      for (int i = 0; i < KD; i++) cyc(1'b1, (i == 2) ? 3'(1 << l) : 3'b000, 1'b1);
      for (int i = 0; i < KD; i++) cyc(1'b1, 3'b000, 1'b1);
    end
    // R4: sparse valid with junk on idle cycles
    tag = "R4";
    for (int i = 0; i < 30 * KD; i++)
      cyc(($urandom % 10) < 4, 3'($urandom), 1'b1);
    // R6: consumer stalls within one period
    tag = "R6";
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < KD; i++) cyc(1'b1, 3'($urandom), 1'b0);
      for (int i = 0; i < 3; i++) cyc(1'b0, 3'($urandom), 1'b0);
      cyc(1'b0, 3'b000, 1'b1);
    end
    // R8: stall across several completions, newest bit replaces held bit
    tag = "R8";
    for (int i = 0; i < 5 * KD; i++) cyc(1'b1, 3'($urandom), 1'b0);
    cyc(1'b0, 3'b000, 1'b1);
    cyc(1'b0, 3'b000, 1'b1);
    // R7: take a held bit in the very cycle the next period completes
    tag = "R7";
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < KD; i++) cyc(1'b1, 3'($urandom), (i == KD - 1));
    // R1: reset in mid-period, then a full KD is needed again
    tag = "R1";
    for (int i = 0; i < 3; i++) cyc(1'b1, 3'b001, 1'b1);
    @(negedge clk); compare(); rst = 1'b1;
    @(negedge clk); compare(); rst = 1'b0;
    for (int i = 0; i < 3 * KD; i++) cyc(1'b1, 3'($urandom), 1'b1);
    cyc(1'b0, 3'b000, 1'b1);
    finish_run();
  end
endmodule